// File: doc/BRIEF.md
# Processor Power-Mode Sequencer

This block steps a processor core between full power and three reduced-power levels: doze, nap and sleep. Software picks a level by writing a mode word. The block then gates the clock enables of the functional units, and it drives the snoop, data-cache and time-base enables so that coherency is kept for as long as the chosen level allows. In doze the bus interface stays clocked and snooping stays on. A snoop hit while dozing wakes only the data cache for a copy-back, then the block falls back to doze. Nap and sleep switch snooping off, so the block first raises a quiesce request and waits for the system's acknowledge before it goes down.

Wake sources are the external interrupt, the system-management interrupt, the machine check and the decrementer event. The decrementer event counts only while the time base is enabled, so it does nothing in sleep. Wake inputs are level signals and stay high until they are serviced. A wake seen during a low state clears the three level bits, so the core does not drop straight back down. A wake seen while entry is still in progress aborts the entry.

The copy-back request uses valid/ready. `cb_valid` rises the cycle after the snoop hit and stays high, unchanged, until `cb_ready` is sampled high with it. The copy-back completes on that edge. `cb_ready` has no effect while `cb_valid` is low.

Top module: `pwr_mode_seq`

## Requirements
- R1: A write on `mode_wr` loads the level bits from `mode_wdata`: bit 8 requests doze, bit 9 requests nap and bit 10 requests sleep. When several are set, sleep wins over nap and nap wins over doze.
- R2: After a doze write, `pstate` reads 1 exactly ENTRY_DLY+1 clock edges after the write edge. In doze, `unit_clk_en` has only bit BIU_IDX set, `snoop_en` and `tb_en` are high and `dcache_en` is low.
- R3: A `snoop_hit` sampled in doze raises `cb_valid` and `dcache_en` on the next edge. After the copy-back handshake the block is back in doze with `dcache_en` low.
- R4: A nap or sleep write raises `qreq` one edge after the write edge. While `qack` stays low, `pstate` stays 0 and `snoop_en` stays high.
- R5: The edge that samples `qack` high while `qreq` is high drops `snoop_en`. `pstate` shows the low level ENTRY_DLY edges later. In nap (`pstate`=2), all unit clock enables are low, `snoop_en` is low and `tb_en` is high.
- R6: In sleep (`pstate`=3), `tb_en` is low and so are all unit clock enables. `dec_evt` does not wake the block.
- R7: From doze or nap, `ext_int`, `smi`, `mchk` or `dec_evt` wakes the block. From sleep, `ext_int`, `smi` or `mchk` wakes it. `pstate` returns to 0 with every enable high WAKE_LAT edges after the wake is sampled, and `qreq` falls on that first edge. The level bits are cleared, so no new entry follows.
- R8: An interrupt sampled while `qreq` is high and `pstate` is 0 aborts the entry. `qreq` falls on that edge, `pstate` stays 0 and the level bits are cleared.
- R9: `soft_rst` returns the block to full power with `qreq` low and the level bits cleared on the next edge. A low `rst_n` does the same at once, without waiting for a clock edge.
- R10: `snoop_hit` has no effect in nap or sleep: `cb_valid` stays low and `pstate` does not change.
- R11: Once high, `cb_valid` stays high until an edge at which `cb_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | MODE_W | Mode word; bits 8, 9 and 10 are the level bits |
| ext_int | input | 1 | External interrupt (level) |
| smi | input | 1 | System-management interrupt (level) |
| mchk | input | 1 | Machine check (level) |
| dec_evt | input | 1 | Decrementer event from the time base |
| snoop_hit | input | 1 | Bus snoop hit on a modified line |
| qack | input | 1 | Quiesce acknowledge from the system |
| cb_ready | input | 1 | Copy-back accepted |
| qreq | output | 1 | Quiesce request |
| unit_clk_en | output | NUM_UNITS | Per-unit clock enables |
| snoop_en | output | 1 | Bus snooping enable |
| dcache_en | output | 1 | Data cache enable |
| tb_en | output | 1 | Time base / decrementer enable |
| cb_valid | output | 1 | Copy-back request valid |
| pstate | output | 2 | Level: 0 full, 1 doze, 2 nap, 3 sleep |

## Verification
Entry is tried with single-bit writes for each level and with multi-bit writes. The multi-bit writes show whether the priority picks the deepest level and not the shallowest. Wake is tried with every source against every level: `dec_evt` must wake doze and nap but not sleep, which separates correct time-base gating from a wake path that is simply wired to everything. Snoop hits are applied in doze with several `cb_ready` delays and in nap, which shows whether the copy-back handshake holds and whether snooping really stops once the quiesce handshake is done. Interrupts during the quiesce wait, a soft reset in nap and an asynchronous reset in sleep show whether every exit clears `qreq` and the level bits.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [3:0] {
    ST_FULL,
    ST_DOZE_ENT,
    ST_DOZE,
    ST_COPYBACK,
    ST_QREQ,
    ST_LP_ENT,
    ST_NAP,
    ST_SLEEP,
    ST_WAKE
  } pwr_st_e;

  typedef enum logic [1:0] {
    LVL_FULL  = 2'd0,
    LVL_DOZE  = 2'd1,
    LVL_NAP   = 2'd2,
    LVL_SLEEP = 2'd3
  } pwr_lvl_e;

endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
#(
  parameter int MODE_W    = 32,
  parameter int DOZE_BIT  = 8,
  parameter int NAP_BIT   = 9,
  parameter int SLEEP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              clr_lvl,
  output pwr_lvl_e          req_lvl
);

  logic doze_q, nap_q, sleep_q;
  logic unused_wdata;

  // Only the three level bits are held; the rest of the word has no function here.
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doze_q  <= 1'b0;
      nap_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else if (soft_rst) begin
      doze_q  <= 1'b0;
      nap_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else if (wr_en) begin
      doze_q  <= wr_data[DOZE_BIT];
      nap_q   <= wr_data[NAP_BIT];
      sleep_q <= wr_data[SLEEP_BIT];
    end else if (clr_lvl) begin
      doze_q  <= 1'b0;
      nap_q   <= 1'b0;
      sleep_q <= 1'b0;
    end
  end

  // Deepest requested level wins.
  always_comb begin
    if (sleep_q)     req_lvl = LVL_SLEEP;
    else if (nap_q)  req_lvl = LVL_NAP;
    else if (doze_q) req_lvl = LVL_DOZE;
    else             req_lvl = LVL_FULL;
  end

endmodule

// File: rtl/pwr_step_ctr.sv
module pwr_step_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] lim,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  // The final step of a window of lim edges.
  assign done = run && (cnt_q == lim - 1'b1);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  pwr_lvl_e req_lvl,
  input  logic     irq_any,
  input  logic     dec_evt,
  input  logic     snoop_hit,
  input  logic     qack,
  input  logic     cb_ready,
  input  logic     ctr_done,
  output pwr_st_e  state,
  output pwr_lvl_e tgt,
  output logic     clr_lvl,
  output logic     ctr_run
);

  pwr_st_e  st_q, st_d;
  pwr_lvl_e tgt_q, tgt_d;
  logic     wake;

  // The decrementer only counts while the time base runs, which is every level except sleep.
  assign wake = irq_any || (dec_evt && (tgt_q != LVL_SLEEP));

  always_comb begin
    st_d    = st_q;
    tgt_d   = tgt_q;
    clr_lvl = 1'b0;
    unique case (st_q)
      ST_FULL: begin
        if (req_lvl == LVL_DOZE) begin
          tgt_d = LVL_DOZE;
          st_d  = ST_DOZE_ENT;
        end else if (req_lvl != LVL_FULL) begin
          tgt_d = req_lvl;
          st_d  = ST_QREQ;
        end
      end
      ST_DOZE_ENT: begin
        if (wake) begin
          st_d    = ST_FULL;
          clr_lvl = 1'b1;
        end else if (ctr_done) begin
          st_d = ST_DOZE;
        end
      end
      ST_QREQ: begin
        if (wake) begin
          st_d    = ST_FULL;
          clr_lvl = 1'b1;
        end else if (qack) begin
          st_d = ST_LP_ENT;
        end
      end
      ST_LP_ENT: begin
        if (wake) begin
          st_d    = ST_FULL;
          clr_lvl = 1'b1;
        end else if (ctr_done) begin
          st_d = (tgt_q == LVL_SLEEP) ? ST_SLEEP : ST_NAP;
        end
      end
      ST_DOZE: begin
        if (wake) begin
          st_d    = ST_WAKE;
          clr_lvl = 1'b1;
        end else if (snoop_hit) begin
          st_d = ST_COPYBACK;
        end
      end
      ST_COPYBACK: begin
        if (cb_ready) st_d = ST_DOZE;
      end
      ST_NAP, ST_SLEEP: begin
        if (wake) begin
          st_d    = ST_WAKE;
          clr_lvl = 1'b1;
        end
      end
      ST_WAKE: begin
        if (ctr_done) st_d = ST_FULL;
      end
      default: st_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FULL;
      tgt_q <= LVL_FULL;
    end else if (soft_rst) begin
      st_q  <= ST_FULL;
      tgt_q <= LVL_FULL;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  assign state   = st_q;
  assign tgt     = tgt_q;
  assign ctr_run = (st_q == ST_DOZE_ENT) || (st_q == ST_LP_ENT) || (st_q == ST_WAKE);

endmodule

// File: rtl/pwr_gate_dec.sv
module pwr_gate_dec
  import pwr_mode_pkg::*;
#(
  parameter int NUM_UNITS  = 8,
  parameter int BIU_IDX    = 0,
  parameter int DCACHE_IDX = 1
) (
  input  pwr_st_e               state,
  input  pwr_lvl_e              tgt,
  output logic [NUM_UNITS-1:0]  unit_clk_en,
  output logic                  snoop_en,
  output logic                  dcache_en,
  output logic                  tb_en,
  output logic                  qreq,
  output logic                  cb_valid,
  output logic [1:0]            pstate
);

  pwr_lvl_e lvl_now;
  logic     full_on, doze_on, cb_on;

  // The committed level is held through the wake window as well.
  always_comb begin
    unique case (state)
      ST_DOZE, ST_COPYBACK, ST_NAP, ST_SLEEP, ST_WAKE: lvl_now = tgt;
      default:                                         lvl_now = LVL_FULL;
    endcase
  end

  assign full_on = (lvl_now == LVL_FULL);
  assign doze_on = (lvl_now == LVL_DOZE);
  assign cb_on   = (state == ST_COPYBACK);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    if (u == BIU_IDX) begin : g_biu
      assign unit_clk_en[u] = full_on || doze_on;
    end else if (u == DCACHE_IDX) begin : g_dc
      assign unit_clk_en[u] = full_on || cb_on;
    end else begin : g_other
      assign unit_clk_en[u] = full_on;
    end
  end

  assign snoop_en  = (full_on || doze_on) && (state != ST_LP_ENT);
  assign dcache_en = full_on || cb_on;
  assign tb_en     = (lvl_now != LVL_SLEEP);
  assign qreq      = (state == ST_QREQ) || (state == ST_LP_ENT) ||
                     (state == ST_NAP)  || (state == ST_SLEEP);
  assign cb_valid  = cb_on;
  assign pstate    = lvl_now;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int MODE_W     = 32,
  parameter int NUM_UNITS  = 8,
  parameter int BIU_IDX    = 0,
  parameter int DCACHE_IDX = 1,
  parameter int ENTRY_DLY  = 4,
  parameter int WAKE_LAT   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 mode_wr,
  input  logic [MODE_W-1:0]    mode_wdata,
  input  logic                 ext_int,
  input  logic                 smi,
  input  logic                 mchk,
  input  logic                 dec_evt,
  input  logic                 snoop_hit,
  input  logic                 qack,
  input  logic                 cb_ready,
  output logic                 qreq,
  output logic [NUM_UNITS-1:0] unit_clk_en,
  output logic                 snoop_en,
  output logic                 dcache_en,
  output logic                 tb_en,
  output logic                 cb_valid,
  output logic [1:0]           pstate
);

  localparam int MAX_DLY = (ENTRY_DLY > WAKE_LAT) ? ENTRY_DLY : WAKE_LAT;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] ENT_LIM  = CNT_W'(ENTRY_DLY);
  localparam logic [CNT_W-1:0] WAKE_LIM = CNT_W'(WAKE_LAT);

  pwr_lvl_e         req_lvl, tgt;
  pwr_st_e          state;
  logic             clr_lvl, ctr_run, ctr_done;
  logic [CNT_W-1:0] ctr_lim;

  pwr_mode_reg #(
    .MODE_W(MODE_W), .DOZE_BIT(8), .NAP_BIT(9), .SLEEP_BIT(10)
  ) i_mode (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(mode_wr), .wr_data(mode_wdata), .clr_lvl(clr_lvl),
    .req_lvl(req_lvl)
  );

  assign ctr_lim = (state == ST_WAKE) ? WAKE_LIM : ENT_LIM;

  pwr_step_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .run(ctr_run && !soft_rst),
    .lim(ctr_lim), .done(ctr_done)
  );

  pwr_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_lvl(req_lvl), .irq_any(ext_int || smi || mchk), .dec_evt(dec_evt),
    .snoop_hit(snoop_hit), .qack(qack), .cb_ready(cb_ready),
    .ctr_done(ctr_done), .state(state), .tgt(tgt),
    .clr_lvl(clr_lvl), .ctr_run(ctr_run)
  );

  pwr_gate_dec #(
    .NUM_UNITS(NUM_UNITS), .BIU_IDX(BIU_IDX), .DCACHE_IDX(DCACHE_IDX)
  ) i_dec (
    .state(state), .tgt(tgt),
    .unit_clk_en(unit_clk_en), .snoop_en(snoop_en), .dcache_en(dcache_en),
    .tb_en(tb_en), .qreq(qreq), .cb_valid(cb_valid), .pstate(pstate)
  );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int NUM_UNITS = 8,
  parameter int BIU_IDX   = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 soft_rst,
  input logic                 ext_int,
  input logic                 smi,
  input logic                 mchk,
  input logic                 snoop_hit,
  input logic                 cb_ready,
  input logic                 qreq,
  input logic [NUM_UNITS-1:0] unit_clk_en,
  input logic                 snoop_en,
  input logic                 dcache_en,
  input logic                 tb_en,
  input logic                 cb_valid,
  input logic [1:0]           pstate
);

  localparam logic [NUM_UNITS-1:0] BIU_MASK = NUM_UNITS'(1) << BIU_IDX;

  // R11
  cb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (cb_valid && !cb_ready) |=> cb_valid);

  // R2
  doze_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd1 && !cb_valid) |-> (unit_clk_en == BIU_MASK && snoop_en && !dcache_en && tb_en));

  // R5
  nap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd2) |-> (unit_clk_en == '0 && !snoop_en && tb_en));

  // R6
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd3) |-> (unit_clk_en == '0 && !snoop_en && !tb_en));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qreq && pstate == 2'd0 && (ext_int || smi || mchk)) |=> (!qreq && pstate == 2'd0));

  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pstate == 2'd0 && !qreq));

  // R10
  nap_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && pstate[1]) |=> !cb_valid);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NUM_UNITS(NUM_UNITS), .BIU_IDX(BIU_IDX)) i_pwr_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ext_int(ext_int), .smi(smi),
  .mchk(mchk), .snoop_hit(snoop_hit), .cb_ready(cb_ready), .qreq(qreq),
  .unit_clk_en(unit_clk_en), .snoop_en(snoop_en), .dcache_en(dcache_en),
  .tb_en(tb_en), .cb_valid(cb_valid), .pstate(pstate)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

  localparam int MW = 32;
  localparam int NU = 8;
  localparam int BIU = 0;
  localparam int ED = 4;
  localparam int WL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, mode_wr = 1'b0;
  logic [MW-1:0] mode_wdata = '0;
  logic ext_int = 1'b0, smi = 1'b0, mchk = 1'b0, dec_evt = 1'b0;
  logic snoop_hit = 1'b0, qack = 1'b0, cb_ready = 1'b0;
  logic qreq, snoop_en, dcache_en, tb_en, cb_valid;
  logic [NU-1:0] unit_clk_en;
  logic [1:0] pstate;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.MODE_W(MW), .NUM_UNITS(NU), .BIU_IDX(BIU), .DCACHE_IDX(1),
                 .ENTRY_DLY(ED), .WAKE_LAT(WL)) i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .ext_int(ext_int), .smi(smi), .mchk(mchk),
    .dec_evt(dec_evt), .snoop_hit(snoop_hit), .qack(qack), .cb_ready(cb_ready),
    .qreq(qreq), .unit_clk_en(unit_clk_en), .snoop_en(snoop_en),
    .dcache_en(dcache_en), .tb_en(tb_en), .cb_valid(cb_valid), .pstate(pstate)
  );

  function automatic logic [NU-1:0] exp_units(int lvl);
    if (lvl == 0) return '1;
    if (lvl == 1) return NU'(1) << BIU;
    return '0;
  endfunction
  function automatic bit exp_snoop(int lvl); return lvl <= 1; endfunction
  function automatic bit exp_tb(int lvl);    return lvl != 3; endfunction
  function automatic int lvl_of(logic [2:0] bits);
    if (bits[2]) return 3;
    if (bits[1]) return 2;
    if (bits[0]) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic check_level(input int lvl, input string req);
    chk(int'(pstate) == lvl, {req, " pstate"}, int'(pstate), lvl);
    chk(unit_clk_en == exp_units(lvl), {req, " unit_clk_en"}, int'(unit_clk_en), int'(exp_units(lvl)));
    chk(snoop_en == exp_snoop(lvl), {req, " snoop_en"}, int'(snoop_en), int'(exp_snoop(lvl)));
    chk(tb_en == exp_tb(lvl), {req, " tb_en"}, int'(tb_en), int'(exp_tb(lvl)));
  endtask

  task automatic write_bits(input logic [2:0] bits);
    mode_wr = 1'b1;
    mode_wdata = MW'(bits) << 8;
    @(negedge clk);
    mode_wr = 1'b0;
    mode_wdata = '0;
  endtask

  // Enters the level selected by bits; qack is withheld for hold_n cycles.
  task automatic enter(input logic [2:0] bits, input int hold_n);
    int lvl = lvl_of(bits);
    int n = 1;
    write_bits(bits);
    if (lvl == 1) begin
      while (int'(pstate) != 1 && n < 40) begin @(negedge clk); n++; end
      chk(n == ED + 2, "R2 doze entry cycles", n, ED + 2);
    end else begin
      @(negedge clk);
      chk(qreq == 1'b1, "R4 qreq after write", int'(qreq), 1);
      for (int k = 0; k < hold_n; k++) begin
        chk(int'(pstate) == 0 && snoop_en, "R4 waiting for qack", int'(pstate), 0);
        @(negedge clk);
      end
      qack = 1'b1;
      @(negedge clk);
      qack = 1'b0;
      n = 1;
      chk(snoop_en == 1'b0, "R5 snoop off after qack", int'(snoop_en), 0);
      while (int'(pstate) != lvl && n < 40) begin @(negedge clk); n++; end
      chk(n == ED + 1, "R5 low-power entry cycles", n, ED + 1);
    end
    check_level(lvl, lvl == 1 ? "R2" : (lvl == 2 ? "R5" : "R6"));
  endtask

  // src: 0 ext_int, 1 smi, 2 mchk, 3 dec_evt
  task automatic wake(input int src);
    int n = 1;
    case (src)
      0: ext_int = 1'b1;
      1: smi = 1'b1;
      2: mchk = 1'b1;
      default: dec_evt = 1'b1;
    endcase
    @(negedge clk);
    chk(qreq == 1'b0, "R7 qreq dropped on wake", int'(qreq), 0);
    while (int'(pstate) != 0 && n < 40) begin @(negedge clk); n++; end
    chk(n == WL + 1, "R7 wake latency", n, WL + 1);
    {ext_int, smi, mchk, dec_evt} = '0;
    check_level(0, "R7 full restored");
    repeat (ED + 4) @(negedge clk);
    chk(int'(pstate) == 0 && !qreq, "R7 level bits cleared", int'(pstate), 0);
  endtask

  task automatic snoop_service(input int delay);
    snoop_hit = 1'b1;
    @(negedge clk);
    snoop_hit = 1'b0;
    chk(cb_valid && dcache_en, "R3 copy-back requested", int'(cb_valid), 1);
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      chk(cb_valid == 1'b1, "R11 cb_valid held", int'(cb_valid), 1);
    end
    cb_ready = 1'b1;
    @(negedge clk);
    cb_ready = 1'b0;
    chk(!cb_valid && !dcache_en, "R3 cache off after copy-back", int'(cb_valid), 0);
    check_level(1, "R3 back in doze");
  endtask

  task automatic snoop_ignored(input int lvl);
    snoop_hit = 1'b1;
    @(negedge clk);
    snoop_hit = 1'b0;
    @(negedge clk);
    chk(!cb_valid && int'(pstate) == lvl, "R10 snoop hit ignored", int'(cb_valid), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: reset state
    check_level(0, "R9 reset");
    chk(!qreq && !cb_valid && dcache_en, "R9 reset qreq/cb", int'(qreq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2, R3, R7: doze, copy-back, interrupt wake
    enter(3'b001, 0);
    snoop_service(3);
    wake(0);

    // R4, R5, R10, R7: nap with delayed qack, ignored snoop, decrementer wake
    enter(3'b010, 5);
    snoop_ignored(2);
    wake(3);

    // R6: sleep ignores the decrementer
    enter(3'b100, 1);
    dec_evt = 1'b1;
    repeat (4) @(negedge clk);
    dec_evt = 1'b0;
    check_level(3, "R6 dec_evt ignored in sleep");
    wake(1);

    // R1 priority nap over doze, R8 abort during qack wait
    write_bits(3'b011);
    @(negedge clk);
    chk(qreq && int'(pstate) == 0, "R1 nap beats doze", int'(qreq), 1);
    mchk = 1'b1;
    @(negedge clk);
    chk(!qreq && int'(pstate) == 0, "R8 abort drops qreq", int'(qreq), 0);
    mchk = 1'b0;
    repeat (ED + 4) @(negedge clk);
    chk(!qreq && int'(pstate) == 0, "R8 no re-entry", int'(qreq), 0);

    // R1 priority sleep over nap
    enter(3'b110, 0);
    wake(2);

    // R9 soft reset in nap
    enter(3'b010, 2);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check_level(0, "R9 soft reset");
    chk(!qreq, "R9 soft reset qreq", int'(qreq), 0);
    repeat (ED + 4) @(negedge clk);
    chk(int'(pstate) == 0 && !qreq, "R9 soft reset cleared bits", int'(pstate), 0);

    // R9 asynchronous hard reset in sleep
    enter(3'b100, 0);
    #2 rst_n = 1'b0;
    #1;
    check_level(0, "R9 hard reset");
    chk(!qreq, "R9 hard reset qreq", int'(qreq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      int lvl = int'($urandom_range(1, 3));
      int src = int'($urandom_range(0, 3));
      enter(3'b001 << (lvl - 1), int'($urandom_range(0, 3)));
      if (lvl == 1 && $urandom_range(0, 1) == 1) snoop_service(int'($urandom_range(0, 4)));
      if (lvl >= 2 && $urandom_range(0, 1) == 1) snoop_ignored(lvl);
      if (lvl == 3 && src == 3) begin
        dec_evt = 1'b1;
        repeat (3) @(negedge clk);
        dec_evt = 1'b0;
        chk(int'(pstate) == 3, "R6 random dec in sleep", int'(pstate), 3);
        src = 0;
      end
      wake(src);
    end

    report();
    $finish;
  end

endmodule